// File: doc/BRIEF.md
# Chained Descriptor DMA Engine for HDLC Frames

This block is a single-channel DMA engine. It moves the bytes of HDLC frames between a byte stream and buffers held in a shared byte-wide memory. Work is described by a chain of descriptors in that memory. Each descriptor is 9 bytes long. The engine starts at the descriptor named by its current-descriptor register and follows the next-pointers from there. It stops before the descriptor whose address equals the end-descriptor register. Software hands descriptors back to the engine by moving that end address forward.

The direction is set by a mode bit. In receive mode, incoming bytes fill buffers of a programmable length, and a frame may spread over several descriptors. The engine writes a byte count and a status byte into every descriptor it uses. A frame that finds no free descriptor is swallowed and flagged as an overflow. In transmit mode, the engine reads each buffer out to the stream. It marks the last byte of any descriptor whose status has the end-of-message bit set.

Software reaches the engine through a small word-wide register port. Reads are combinational and writes take effect at the clock edge. The register map is:

| Offset | Register | Contents |
|---|---|---|
| 0 | current descriptor | descriptor address |
| 1 | end descriptor | descriptor address |
| 2 | buffer length | receive buffer length |
| 3 | status | flags and DMA enable |
| 4 | command | write-only commands |
| 5 | mode | direction and interrupt enables |
| 6 | frame counter | count of completed frames |

Top module: `hdlc_chain_dma`

## Requirements
- R1: After reset the following all read 0: the status register (offset 3), the frame counter (offset 6) and the mode register (offset 5). irq, rx_ready and tx_valid are also low.
- R2: A descriptor at byte address A holds four little-endian fields:
  - the next-descriptor pointer at A+0..A+1;
  - the 32-bit buffer address at A+2..A+5;
  - the byte length at A+6..A+7;
  - the status byte at A+8.
  Data byte n of a descriptor is at buffer address + n. When a descriptor is finished, the current-descriptor register (offset 0) takes that descriptor's next pointer.
- R3: The engine never reads, writes or transfers for the descriptor whose address equals the end-descriptor register (offset 1). When the current address advances onto the end address, status bit 7 (end of transfer) is set. In transmit mode, sitting at the end address clears DMA enable (status bit 1).
- R4: In receive mode (mode bit 0 = 0), a descriptor fills to the buffer length (offset 2, at least 1). If the frame is not over, the engine writes length = buffer length and status = 0x00 into that descriptor, and the frame continues in the next descriptor.
- R5: The descriptor that holds a received frame's last byte gets two values written back:
  - length = the number of bytes in that descriptor;
  - status = 0x80 | rx_flags<<2, where rx_flags bit 4 is short frame, bit 3 abort, bit 2 residual bits, bit 1 overrun and bit 0 CRC error.

  A frame of exactly the buffer length uses one descriptor.
- R6: A receive frame that starts or continues while the current address equals the end address behaves as follows: all of its bytes are accepted with rx_ready high, none is written to memory, and status bit 5 (buffer overflow) is set.
- R7: In transmit mode (mode bit 0 = 1), the engine sends the length bytes of each descriptor in order. tx_last is high on the final byte of a descriptor whose status bit 7 is set. tx_data and tx_last hold while tx_valid is high and tx_ready is low. The engine writes no memory in transmit mode.
- R8: A completed frame is either a received frame's last descriptor written back, or a transmit descriptor with status bit 7 fully sent. Each completed frame sets status bit 6 (end of message) and increments the frame counter. An increment from all ones wraps to 0 and sets status bit 4 (counter overflow). Writing command bit 1 (offset 4) clears the counter.
- R9: In a write to the status register:
  - a 1 in bits 7..4 clears that flag;
  - DMA enable (bit 1) changes only when bit 0 is 1 in the same write;
  - writing 0x0000 clears DMA enable and halts the channel.
- R10: Writing command bit 0 (abort) makes the engine idle at the next edge. DMA enable clears, tx_valid and rx_ready go low, and any partial receive frame is forgotten.
- R11: A halted or blocked channel resumes from the current descriptor when the end address has been moved past it and DMA enable is set.
- R12: irq is high exactly when (status bit 6 and mode bit 1) or (status bit 5 and mode bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Read byte, valid the cycle after a read strobe |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive byte accepted |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Last byte of the receive frame |
| rx_flags | input | 5 | Frame error flags, taken with the last byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit byte accepted |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Last byte of a transmit frame |

## Verification
The assertions check a set of properties on every cycle:
- the transmit stream holds steady under backpressure;
- transmit mode never writes memory;
- an abort leaves both streams idle and DMA disabled;
- a zero status write halts the channel.

Other behaviour can only be seen through the bench's scenarios:
- the chain walk and the write-back of length and status;
- frames split across buffers, including the exact-fit case;
- frames dropped at the end address, with memory left untouched;
- counter wrap, flag clearing and the resume after moving the end address.

The bench checks these against descriptor contents that it computes itself.

// File: rtl/hdlc_chain_dma.sv
module hdlc_chain_dma #(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic [4:0]  rx_flags,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last
);
  localparam logic [3:0] DESC_LAST = 4'd9;
  localparam logic [31:0] LEN_OFS = 32'd6;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_RXDAT, S_RXWB, S_DROP, S_TXRD, S_TXCAP, S_TXOUT
  } st_t;

  st_t st;
  logic [15:0] cda, eda, blen, nxt, dlen, cnt, wlen;
  logic [31:0] bufa;
  logic [7:0]  wstat, obyte;
  logic [3:0]  idx;
  logic [CNT_W-1:0] efc;
  logic eot, eom, bof, cof, de, txm, ie_eom, ie_bof;
  logic teom, fin, midf;

  wire at_end  = (cda == eda);
  wire wr_st   = reg_we && reg_addr == 3'd3;
  wire wr_cmd  = reg_we && reg_addr == 3'd4;
  wire rx_take = rx_valid && rx_ready;
  wire [15:0] cnt1 = cnt + 16'd1;

  wire tx_byte_done = st == S_TXOUT && tx_ready && cnt1 == dlen;
  wire tx_empty     = st == S_FETCH && idx == DESC_LAST && txm && dlen == 16'd0;
  wire wb_done      = st == S_RXWB && idx == 4'd2;
  wire desc_done    = wb_done || tx_byte_done || tx_empty;
  wire frame_done   = (wb_done && fin) || (tx_byte_done && teom) ||
                      (tx_empty && mem_rdata[7]);

  assign rx_ready = !txm && (st == S_RXDAT || st == S_DROP);
  assign tx_valid = st == S_TXOUT;
  assign tx_data  = obyte;
  assign tx_last  = teom && cnt1 == dlen;
  assign irq      = (eom && ie_eom) || (bof && ie_bof);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = {16'h0, cda} + {28'h0, idx};
    mem_wdata = rx_data;
    case (st)
      S_FETCH: mem_req = idx < DESC_LAST;
      S_RXDAT: begin
        mem_req  = rx_take;
        mem_we   = 1'b1;
        mem_addr = bufa + {16'h0, cnt};
      end
      S_RXWB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {16'h0, cda} + LEN_OFS + {28'h0, idx};
        mem_wdata = idx == 4'd0 ? wlen[7:0] : idx == 4'd1 ? wlen[15:8] : wstat;
      end
      S_TXRD: begin
        mem_req  = 1'b1;
        mem_addr = bufa + {16'h0, cnt};
      end
      default: ;
    endcase
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = cda;
      3'd1:    reg_rdata = eda;
      3'd2:    reg_rdata = blen;
      3'd3:    reg_rdata = {8'h0, eot, eom, bof, cof, 2'b00, de, 1'b0};
      3'd5:    reg_rdata = {13'h0, ie_bof, ie_eom, txm};
      3'd6:    reg_rdata = 16'(efc);
      default: reg_rdata = 16'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cda <= '0; eda <= '0; blen <= '0; nxt <= '0; dlen <= '0; cnt <= '0;
      wlen <= '0; bufa <= '0; wstat <= '0; obyte <= '0; idx <= '0; efc <= '0;
      eot <= 1'b0; eom <= 1'b0; bof <= 1'b0; cof <= 1'b0; de <= 1'b0;
      txm <= 1'b0; ie_eom <= 1'b0; ie_bof <= 1'b0;
      teom <= 1'b0; fin <= 1'b0; midf <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          3'd0: cda  <= reg_wdata;
          3'd1: eda  <= reg_wdata;
          3'd2: blen <= reg_wdata;
          3'd5: {ie_bof, ie_eom, txm} <= reg_wdata[2:0];
          default: ;
        endcase
      end
      if (wr_st) begin
        eot <= eot & ~reg_wdata[7];
        eom <= eom & ~reg_wdata[6];
        bof <= bof & ~reg_wdata[5];
        cof <= cof & ~reg_wdata[4];
        if (reg_wdata == 16'h0) de <= 1'b0;
        else if (reg_wdata[0]) de <= reg_wdata[1];
      end
      if (wr_cmd && reg_wdata[1]) efc <= '0;

      case (st)
        S_IDLE: if (de) begin
          if (!at_end) begin
            st  <= S_FETCH;
            idx <= '0;
          end else if (txm) begin
            de <= 1'b0;
          end else if (midf || rx_valid) begin
            st  <= S_DROP;
            bof <= 1'b1;
          end
        end
        S_FETCH: begin
          idx <= idx + 4'd1;
          case (idx)
            4'd1: nxt[7:0]    <= mem_rdata;
            4'd2: nxt[15:8]   <= mem_rdata;
            4'd3: bufa[7:0]   <= mem_rdata;
            4'd4: bufa[15:8]  <= mem_rdata;
            4'd5: bufa[23:16] <= mem_rdata;
            4'd6: bufa[31:24] <= mem_rdata;
            4'd7: dlen[7:0]   <= mem_rdata;
            4'd8: dlen[15:8]  <= mem_rdata;
            DESC_LAST: begin
              teom <= mem_rdata[7];
              cnt  <= '0;
              if (!txm) st <= S_RXDAT;
              else st <= (dlen == 16'd0) ? S_IDLE : S_TXRD;
            end
            default: ;
          endcase
        end
        S_RXDAT: if (rx_take) begin
          if (rx_last || cnt1 == blen) begin
            wlen  <= cnt1;
            wstat <= rx_last ? {1'b1, rx_flags, 2'b00} : 8'h00;
            fin   <= rx_last;
            idx   <= '0;
            st    <= S_RXWB;
          end else begin
            cnt <= cnt1;
          end
        end
        S_RXWB: begin
          idx <= idx + 4'd1;
          if (idx == 4'd2) begin
            st   <= S_IDLE;
            midf <= !fin;
          end
        end
        S_DROP: if (rx_take && rx_last) begin
          st   <= S_IDLE;
          midf <= 1'b0;
        end
        S_TXRD:  st <= S_TXCAP;
        S_TXCAP: begin
          obyte <= mem_rdata;
          st    <= S_TXOUT;
        end
        S_TXOUT: if (tx_ready) begin
          if (cnt1 == dlen) st <= S_IDLE;
          else begin
            cnt <= cnt1;
            st  <= S_TXRD;
          end
        end
        default: st <= S_IDLE;
      endcase

      if (desc_done) begin
        cda <= nxt;
        if (nxt == eda) eot <= 1'b1;
      end
      if (frame_done) begin
        eom <= 1'b1;
        efc <= efc + CNT_W'(1);
        if (&efc) cof <= 1'b1;
      end
      if (wr_cmd && reg_wdata[0]) begin
        st   <= S_IDLE;
        de   <= 1'b0;
        midf <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hdlc_chain_dma_chk.sv
module hdlc_chain_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        mem_req,
  input logic        mem_we,
  input logic        rx_ready,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        txm,
  input logic        de
);
  wire abort_wr = reg_we && reg_addr == 3'd4 && reg_wdata[0];

  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !abort_wr |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  p_tx_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !txm);

  p_tx_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> txm);

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> !tx_valid && !rx_ready && !de);

  p_zero_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 3'd3 && reg_wdata == 16'h0 |=> !de);
endmodule

bind hdlc_chain_dma hdlc_chain_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .txm(txm), .de(de)
);

// File: tb/hdlc_chain_dma_bench.sv
module hdlc_chain_dma_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic irq, mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
  logic [7:0] rx_data = '0;
  logic [4:0] rx_flags = '0;
  logic tx_valid, tx_last, tx_ready = 1'b0;
  logic [7:0] tx_data;

  int checks = 0, errors = 0;
  logic [7:0] mem [0:4095];
  logic [7:0] fb [0:63];
  logic [7:0] cap_d [0:63];
  logic cap_l [0:63];
  logic [15:0] rv;

  always #10 clk = ~clk;

  hdlc_chain_dma #(.CNT_W(2)) u_hdlc_chain_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_last(rx_last), .rx_flags(rx_flags),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last));

  always @(posedge clk) if (mem_req) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    else mem_rdata <= mem[mem_addr[11:0]];
  end

  function automatic int dsc(int i); return i * 16; endfunction
  function automatic int bfa(int i); return 256 + 32 * i; endfunction
  function automatic int exp_stat(int fl); return 8'h80 | (fl << 2); endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [15:0] d);
    reg_addr = 3'(a);
    #1 d = reg_rdata;
  endtask

  task automatic mk_desc(int i, int nx, int len, int stat);
    int a = dsc(i), b = bfa(i);
    mem[a] = 8'(nx); mem[a+1] = 8'(nx >> 8);
    mem[a+2] = 8'(b); mem[a+3] = 8'(b >> 8); mem[a+4] = 8'h0; mem[a+5] = 8'h0;
    mem[a+6] = 8'(len); mem[a+7] = 8'(len >> 8); mem[a+8] = 8'(stat);
  endtask

  task automatic ring_rx(int blen, int mode, int n);
    wr(4, 1); wr(3, 16'hF0);
    for (int i = 0; i < n; i++) mk_desc(i, dsc((i + 1) % n), 0, 0);
    wr(2, blen); wr(0, 0); wr(1, dsc(n - 1)); wr(5, mode); wr(3, 3);
  endtask

  task automatic fill(int n);
    for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
  endtask

  task automatic send(int n, int fl);
    @(negedge clk);
    for (int b = 0; b < n; b++) begin
      rx_valid = 1'b1; rx_data = fb[b]; rx_last = (b == n - 1); rx_flags = 5'(fl);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic chk_desc(string tag, int i, int len, int stat, int off);
    chk({tag, " len"}, {mem[dsc(i)+7], mem[dsc(i)+6]}, len);
    chk({tag, " stat"}, mem[dsc(i)+8], stat);
    for (int j = 0; j < len; j++) chk({tag, " data"}, mem[bfa(i)+j], fb[off+j]);
  endtask

  task automatic collect(int n, output int got);
    got = 0;
    for (int t = 0; t < 3000 && got < n; t++) begin
      @(negedge clk);
      tx_ready = ($urandom % 3) != 0;
      if (tx_valid && tx_ready) begin
        cap_d[got] = tx_data; cap_l[got] = tx_last; got++;
      end
    end
    @(negedge clk);
    tx_ready = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int fl, got, blen, len, nd, off, l;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4096; i++) mem[i] = 8'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3, rv); chk("R1 status", rv, 0);
    rd(6, rv); chk("R1 counter", rv, 0);
    rd(5, rv); chk("R1 mode", rv, 0);
    chk("R1 irq", irq, 0); chk("R1 rx_ready", rx_ready, 0); chk("R1 tx_valid", tx_valid, 0);

    ring_rx(8, 6, 6);
    mem[bfa(5)] = 8'hEE;
    fill(5); fl = $urandom % 32; send(5, fl);
    chk_desc("R5 single", 0, 5, exp_stat(fl), 0);
    rd(0, rv); chk("R2 advance", rv, dsc(1));
    rd(6, rv); chk("R8 count", rv, 1);
    rd(3, rv); chk("R8 eom flag", rv & 16'h40, 16'h40);
    chk("R12 irq on eom", irq, 1);
    wr(3, 16'h40);
    rd(3, rv); chk("R9 w1c eom", rv, 16'h02);
    chk("R12 irq clear", irq, 0);

    fill(19); fl = $urandom % 32; send(19, fl);
    chk_desc("R4 span a", 1, 8, 0, 0);
    chk_desc("R4 span b", 2, 8, 0, 8);
    chk_desc("R5 span end", 3, 3, exp_stat(fl), 16);
    rd(6, rv); chk("R8 count span", rv, 2);

    fill(8); fl = $urandom % 32; send(8, fl);
    chk_desc("R5 exact fit", 4, 8, exp_stat(fl), 0);
    rd(3, rv); chk("R3 eot", rv & 16'h80, 16'h80);
    rd(0, rv); chk("R3 at end", rv, dsc(5));

    fill(6); send(6, 3);
    chk("R6 untouched len", {mem[dsc(5)+7], mem[dsc(5)+6]}, 0);
    chk("R6 untouched stat", mem[dsc(5)+8], 0);
    chk("R6 untouched data", mem[bfa(5)], 8'hEE);
    rd(3, rv); chk("R6 bof", rv & 16'h20, 16'h20);
    rd(6, rv); chk("R6 count kept", rv, 3);
    chk("R12 irq on bof", irq, 1);

    wr(3, 16'hB0);
    rd(3, rv); chk("R9 w1c bulk", rv & 16'hB0, 0);
    wr(3, 16'h12);
    rd(3, rv); chk("R9 de gated", rv & 16'h02, 16'h02);
    wr(3, 0);
    rd(3, rv); chk("R9 zero halts", rv & 16'h02, 0);

    wr(1, dsc(1)); wr(3, 3);
    fill(3); fl = $urandom % 32; send(3, fl);
    chk_desc("R11 resume", 5, 3, exp_stat(fl), 0);
    rd(6, rv); chk("R8 wrap", rv, 0);
    rd(3, rv); chk("R8 cof", rv & 16'h10, 16'h10);
    fill(2); fl = $urandom % 32; send(2, fl);
    chk_desc("R2 ring wrap", 0, 2, exp_stat(fl), 0);
    rd(0, rv); chk("R2 cda after wrap", rv, dsc(1));
    wr(4, 2);
    rd(6, rv); chk("R8 clear", rv, 0);

    for (int k = 0; k < 10; k++) begin
      blen = 2 + $urandom % 7;
      len = 1 + $urandom % (blen * 7);
      nd = (len + blen - 1) / blen;
      ring_rx(blen, 6, 8);
      fill(len); fl = $urandom % 32; send(len, fl);
      for (int j = 0; j < nd; j++) begin
        off = j * blen;
        l = (j == nd - 1) ? len - off : blen;
        chk_desc("R4 R5 random", j, l, (j == nd - 1) ? exp_stat(fl) : 0, off);
      end
      if (nd < 7) chk("R3 random next untouched", mem[dsc(nd)+8], 0);
    end

    ring_rx(8, 4, 4);
    fill(3); send(3, 0);
    rd(3, rv); chk("R12 eom set", rv & 16'h40, 16'h40);
    chk("R12 masked irq", irq, 0);

    wr(4, 1); wr(4, 2); wr(3, 16'hF0); wr(5, 3);
    mk_desc(0, dsc(1), 3, 0); mk_desc(1, dsc(2), 2, 8'h80);
    mk_desc(2, dsc(3), 4, 8'h80); mk_desc(3, dsc(4), 0, 0);
    fill(9);
    for (int j = 0; j < 3; j++) mem[bfa(0)+j] = fb[j];
    for (int j = 0; j < 2; j++) mem[bfa(1)+j] = fb[3+j];
    for (int j = 0; j < 4; j++) mem[bfa(2)+j] = fb[5+j];
    wr(0, 0); wr(1, dsc(3)); wr(3, 3);
    collect(9, got);
    chk("R7 byte count", got, 9);
    for (int j = 0; j < 9; j++) begin
      chk("R7 tx byte", cap_d[j], fb[j]);
      chk("R7 tx last", cap_l[j], (j == 4 || j == 8) ? 1 : 0);
    end
    rd(3, rv); chk("R3 tx halt", rv & 16'h82, 16'h80);
    rd(0, rv); chk("R3 tx at end", rv, dsc(3));
    rd(6, rv); chk("R8 tx count", rv, 2);
    chk("R7 no writeback", mem[dsc(0)+8], 0);

    mk_desc(3, dsc(4), 1, 8'h80); mem[bfa(3)] = 8'h5A;
    wr(1, dsc(4)); wr(3, 3);
    collect(1, got);
    chk("R11 tx resume count", got, 1);
    chk("R11 tx resume byte", cap_d[0], 8'h5A);
    chk("R11 tx resume last", cap_l[0], 1);
    rd(6, rv); chk("R8 tx count 3", rv, 3);

    mk_desc(4, dsc(5), 2, 8'h80);
    wr(1, dsc(5)); wr(3, 3);
    tx_ready = 1'b0;
    for (int t = 0; t < 60 && !tx_valid; t++) @(negedge clk);
    chk("R10 tx waiting", tx_valid, 1);
    wr(4, 1);
    chk("R10 abort tx_valid", tx_valid, 0);
    rd(3, rv); chk("R10 abort de", rv & 16'h02, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule